// File: doc/BRIEF.md
# Multi-Channel Digital Silence Detector

This block watches a group of parallel audio channels, each presenting one sample word per sample period together with a shared sample strobe. It drives an active-low silence flag once every channel that takes part in detection has carried nothing but zero samples for a programmed run of consecutive sample periods. By default there are six channels, 24-bit samples and a run of 9600 samples, which is 200 ms of audio at 48 kHz.

Participation is set per channel by an enable bit. When the static-mode input is high, every channel takes part and the enable bits are ignored. A digital mute input forces the flag active whatever the sample content. Downstream logic uses the flag to act on the absence of program material; the capture of samples from the serial interface happens upstream of this block.

Top module: `multi_ch_silence_det`

## Requirements
- R1: After reset the silence flag is high (inactive) and the run of zero samples starts from zero.
- R2: With mute low, the flag goes low right after the clock edge that takes the RUN_LEN-th consecutive strobed sample period in which every participating channel is zero; after RUN_LEN-1 such periods it is still high.
- R3: A strobed sample period in which any participating channel is non-zero restarts the run at zero, and with mute low the flag is high right after that edge.
- R4: The run advances only on clock edges where the sample strobe is high; cycles without the strobe neither advance nor restart the run, whatever the sample data holds.
- R5: With static mode low, only channels whose enable bit is set take part; a non-zero sample on a channel with a clear enable bit has no effect on the run or the flag. Channel i occupies bits [i*SAMPLE_W +: SAMPLE_W] of the sample bus and enable bit i.
- R6: With static mode high, all channels take part and the enable bits are ignored.
- R7: While mute is high the flag is low, whatever the samples, enables or run length.
- R8: With mute low and no participating channel, the flag is high, and a strobe in that state restarts the run.
- R9: The run saturates at RUN_LEN; silence far longer than RUN_LEN keeps the flag low without wrapping back high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_strobe | input | 1 | One-cycle pulse marking a new sample period |
| smp_data | input | NUM_CH*SAMPLE_W | Packed samples, channel i at bits [i*SAMPLE_W +: SAMPLE_W] |
| ch_enable | input | NUM_CH | Per-channel participation bits, used when static mode is low |
| static_mode | input | 1 | High: every channel takes part |
| mute | input | 1 | High: flag forced active |
| silence_n | output | 1 | Active-low silence flag |

## Verification
The bench hits the threshold edge exactly, sampling the flag after RUN_LEN-1 and RUN_LEN zero periods; an off-by-one counter would flip the flag one sample early or late. It holds silence for twice the threshold, where a non-saturating counter would wrap and raise the flag, and it feeds non-zero data between strobes, which a design counting on the system clock or looking at unstrobed data would act on. Noise on disabled channels, the same noise in static mode, an empty participation set and mute with loud samples check that participation and forcing are decoded as specified; a wrong mask would leave the flag low through noise or never let it fall.

// File: rtl/sdet_pkg.sv
package sdet_pkg;
  localparam int unsigned DEF_NUM_CH   = 6;
  localparam int unsigned DEF_SAMPLE_W = 24;
  localparam int unsigned DEF_RUN_LEN  = 9600;

  typedef enum logic [1:0] {
    RUN_HOLD    = 2'd0,
    RUN_ADVANCE = 2'd1,
    RUN_RESTART = 2'd2
  } run_op_e;
endpackage

// File: rtl/sdet_rst_sync.sv
module sdet_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sdet_part_scan.sv
module sdet_part_scan #(
  parameter int unsigned NUM_CH   = sdet_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = sdet_pkg::DEF_SAMPLE_W
) (
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]          ch_enable,
  input  logic                       static_mode,
  output logic [NUM_CH-1:0]          part_mask,
  output logic                       part_loud,
  output logic                       part_none
);
  logic [NUM_CH-1:0] ch_nonzero;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_nonzero[g] = |smp_data[g*SAMPLE_W +: SAMPLE_W];
  end

  always_comb begin
    part_mask = static_mode ? {NUM_CH{1'b1}} : ch_enable;
    part_loud = |(part_mask & ch_nonzero);
    part_none = ~|part_mask;
  end
endmodule

// File: rtl/sdet_run_cnt.sv
module sdet_run_cnt #(
  parameter int unsigned RUN_LEN = sdet_pkg::DEF_RUN_LEN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic restart,
  output logic run_done
);
  import sdet_pkg::*;
  localparam int unsigned CNT_W = $clog2(RUN_LEN + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LEN);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  run_op_e          op;

  always_comb begin
    if (!strobe)                     op = RUN_HOLD;
    else if (restart)                op = RUN_RESTART;
    else if (cnt_q != LIMIT)         op = RUN_ADVANCE;
    else                             op = RUN_HOLD;
    cnt_en = (op != RUN_HOLD);
    unique case (op)
      RUN_RESTART: cnt_d = '0;
      RUN_ADVANCE: cnt_d = cnt_q + 1'b1;
      default:     cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign run_done = (cnt_q == LIMIT);

  assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LIMIT);
  assert_hold_no_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(cnt_q));
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && restart |=> cnt_q == '0);
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !restart && !run_done |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobe && !restart && run_done |=> run_done);
endmodule

// File: rtl/multi_ch_silence_det.sv
module multi_ch_silence_det #(
  parameter int unsigned NUM_CH   = sdet_pkg::DEF_NUM_CH,
  parameter int unsigned SAMPLE_W = sdet_pkg::DEF_SAMPLE_W,
  parameter int unsigned RUN_LEN  = sdet_pkg::DEF_RUN_LEN
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_strobe,
  input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
  input  logic [NUM_CH-1:0]          ch_enable,
  input  logic                       static_mode,
  input  logic                       mute,
  output logic                       silence_n
);
  logic              rst_sync_n;
  logic [NUM_CH-1:0] part_mask;
  logic              part_loud;
  logic              part_none;
  logic              run_done;

  sdet_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  sdet_part_scan #(.NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W)) u_scan (
    .smp_data    (smp_data),
    .ch_enable   (ch_enable),
    .static_mode (static_mode),
    .part_mask   (part_mask),
    .part_loud   (part_loud),
    .part_none   (part_none)
  );

  sdet_run_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .strobe   (smp_strobe),
    .restart  (part_loud | part_none),
    .run_done (run_done)
  );

  always_comb begin
    silence_n = ~(mute | (run_done & ~part_none));
  end

  assert_mute_forces_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mute |-> !silence_n);
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !mute && part_mask == '0 |-> silence_n);
  assert_static_all_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    static_mode |-> $countones(part_mask) == NUM_CH);
  assert_loud_release_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smp_strobe && part_loud && !mute ##1 !mute |-> silence_n);
endmodule

// File: tb/tb_multi_ch_silence_det.sv
module tb_multi_ch_silence_det;
  localparam int unsigned NCH = 6;
  localparam int unsigned SW  = 24;
  localparam int unsigned RUN = 9600;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              smp_strobe;
  logic [NCH*SW-1:0] smp_data;
  logic [NCH-1:0]    ch_enable;
  logic              static_mode;
  logic              mute;
  logic              silence_n;

  int unsigned mcnt;
  int          checks = 0;
  int          errors = 0;
  int          cycles = 0;

  multi_ch_silence_det #(.NUM_CH(NCH), .SAMPLE_W(SW), .RUN_LEN(RUN)) dut (
    .clk(clk), .rst_n(rst_n), .smp_strobe(smp_strobe), .smp_data(smp_data),
    .ch_enable(ch_enable), .static_mode(static_mode), .mute(mute),
    .silence_n(silence_n)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 190000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [NCH-1:0] mask_of();
    return static_mode ? {NCH{1'b1}} : ch_enable;
  endfunction

  function automatic logic exp_flag();
    return !(mute || (mcnt == RUN && mask_of() != '0));
  endfunction

  function automatic logic [SW-1:0] loud_val();
    logic [SW-1:0] v;
    v = SW'($urandom);
    if (v == '0) v = 1;
    return v;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: silence_n actual %b expected %b (model run %0d)", req, act, exp, mcnt);
    end
  endtask

  task automatic tick(input string req);
    logic [NCH-1:0] m;
    logic loud;
    @(posedge clk);
    if (rst_n && smp_strobe) begin
      m = mask_of();
      loud = 1'b0;
      for (int i = 0; i < NCH; i++)
        if (m[i] && smp_data[i*SW +: SW] != '0) loud = 1'b1;
      if (loud || m == '0) mcnt = 0;
      else if (mcnt < RUN) mcnt++;
    end
    @(negedge clk);
    chk(req, silence_n, exp_flag());
  endtask

  task automatic zeros(input int n, input string req);
    smp_strobe = 1'b1;
    smp_data = '0;
    for (int k = 0; k < n; k++) tick(req);
    smp_strobe = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5D1E_0042));
    rst_n = 1'b0; smp_strobe = 1'b0; smp_data = '0;
    ch_enable = '1; static_mode = 1'b0; mute = 1'b0; mcnt = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick("R1");
    chk("R1", silence_n, 1'b1);

    // R2 threshold edge
    zeros(RUN - 1, "R2");
    chk("R2", silence_n, 1'b1);
    zeros(1, "R2");
    chk("R2", silence_n, 1'b0);
    // R9 long silence saturates
    zeros(RUN + 200, "R9");
    chk("R9", silence_n, 1'b0);
    // R4 loud data without strobe ignored
    smp_data[3*SW +: SW] = loud_val();
    repeat (40) tick("R4");
    chk("R4", silence_n, 1'b0);
    // R3 loud strobe restarts
    smp_strobe = 1'b1; tick("R3"); smp_strobe = 1'b0;
    chk("R3", silence_n, 1'b1);
    zeros(RUN - 1, "R4");
    smp_data[0 +: SW] = loud_val();
    repeat (30) tick("R4");
    zeros(1, "R4");
    chk("R4", silence_n, 1'b0);

    // R5 noise on disabled channels
    ch_enable = 6'b000011;
    smp_strobe = 1'b1;
    for (int k = 0; k < RUN + 5; k++) begin
      smp_data = '0;
      for (int i = 2; i < NCH; i++) smp_data[i*SW +: SW] = loud_val();
      tick("R5");
    end
    chk("R5", silence_n, 1'b0);
    // R6 static mode includes the same noisy channels
    static_mode = 1'b1;
    tick("R6");
    chk("R6", silence_n, 1'b1);
    // R7 mute with loud data
    mute = 1'b1;
    repeat (20) tick("R7");
    chk("R7", silence_n, 1'b0);
    mute = 1'b0; static_mode = 1'b0;
    smp_strobe = 1'b0;
    // R8 no participants
    ch_enable = '0;
    zeros(RUN + 100, "R8");
    chk("R8", silence_n, 1'b1);

    // constrained random segments
    for (int s = 0; s < 5; s++) begin
      int unsigned len, nzp, stp, mtp;
      len = $urandom_range(12000, 9800);
      static_mode = ($urandom_range(3, 0) == 0);
      ch_enable = NCH'($urandom);
      nzp = ($urandom_range(1, 0) == 0) ? 0 : $urandom_range(3000, 2);
      stp = $urandom_range(2, 1);
      mtp = ($urandom_range(1, 0) == 0) ? 0 : 500;
      for (int k = 0; k < len; k++) begin
        smp_strobe = ($urandom_range(stp - 1, 0) == 0);
        if (mtp != 0 && $urandom_range(mtp, 0) == 0) mute = ~mute;
        for (int i = 0; i < NCH; i++) begin
          if (!mask_of()[i]) smp_data[i*SW +: SW] = SW'($urandom);
          else if (nzp != 0 && $urandom_range(nzp, 0) == 0) smp_data[i*SW +: SW] = loud_val();
          else smp_data[i*SW +: SW] = '0;
        end
        tick("R2/R3/R5 random");
      end
      mute = 1'b0;
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule